// File: doc/BRIEF.md
# Directory Coherence Controller

A central controller that keeps coherence for a small set of caching agents, four by default. For each tracked line it holds a presence vector, with one bit per agent, and an exclusive-owner field. Agents send it read misses and requests for write permission. The controller works out which other agents must act. It sends invalidate or writeback commands to those agents and waits for their replies. It then grants the request and brings the directory entry up to date. Agents also report when they drop a line, so that the recorded sharers stay exact.

Only one transaction is in flight at a time. Requests from other agents wait under a ready/valid handshake, and the lowest-numbered waiting agent is served first. No data moves through the block. The writeback to memory appears only as a done pulse on a single input.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset, no grant and no command are issued, and no agent is recorded as holding any line. A first read of any line is therefore granted with no command.
- R2: A read request (op code 0) on a line that has no exclusive owner other than the requester raises the grant in the cycle after acceptance, with no command. The requester is then recorded as a holder of the line.
- R3: An exclusive request (op code 1) on a line that no other agent holds raises the grant in the cycle after acceptance, with no command.
- R4: An exclusive request on a line that other agents hold pulses cmd_valid for exactly those agents, never the requester, in the cycle after acceptance. It uses cmd_kind 0 (invalidate) and cmd_line set to the line.
- R5: The exclusive grant rises in the cycle after the last outstanding acknowledgment arrives. An acknowledgment from an agent that was not sent an invalidate, or a repeated one, neither raises nor hastens the grant.
- R6: A read of a line that another agent owns exclusively pulses cmd_valid for the owner alone, with cmd_kind 1 (writeback), in the cycle after acceptance. The grant rises in the cycle after wb_done. A wb_done pulse that arrives while no writeback is awaited is ignored.
- R7: After an exclusive grant, the requester is the only recorded holder of the line. After a read that forced a writeback, both the former owner and the reader are recorded holders. A later exclusive request from a third agent therefore invalidates exactly that recorded set.
- R8: Only one transaction is served at a time. req_ready is high for at most one agent, and only while idle. When several agents request at once, the lowest index is accepted first.
- R9: Op codes 2 and 3 report an eviction. The requester's presence bit is cleared, along with its ownership if it held any. The eviction is granted in the cycle after acceptance with no command, and the grant reports op code 2.
- R10: During a grant, gnt_agent, gnt_op (0 read, 1 exclusive, 2 eviction) and gnt_line identify the transaction being granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_AGENTS | Request valid, one bit per agent |
| req_op | input | 2*N_AGENTS | Request op code per agent (agent i at bits 2i+1:2i) |
| req_line | input | LINE_W*N_AGENTS | Line index per agent (agent i at slice i) |
| req_ready | output | N_AGENTS | Request accepted this cycle, one bit per agent |
| cmd_valid | output | N_AGENTS | One-cycle command pulse, one bit per target agent |
| cmd_kind | output | 1 | 0 invalidate, 1 writeback |
| cmd_line | output | LINE_W | Line the command refers to |
| ack_valid | input | N_AGENTS | Invalidate acknowledgment, one bit per agent |
| wb_done | input | 1 | Memory reports the writeback complete |
| gnt_valid | output | 1 | Grant pulse |
| gnt_agent | output | AGENT_W | Agent being granted |
| gnt_op | output | 2 | Granted operation class |
| gnt_line | output | LINE_W | Granted line |

## Verification
Exclusive requests are tried against an empty line, a line with two readers, and a line with a single previous owner. Comparing the invalidate vectors across these cases separates the exclusion of the requester from the reset of the sharer set on each grant. Acknowledgments arrive from an uninvolved agent, twice from the same agent, and simultaneously from several agents, which shows that only the full target set releases the grant. Reads of an owned line, reads preceded by a stray wb_done, evictions under both codes, and a two-way request race separate the writeback path, the demotion of the owner and the fixed arbitration order.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_EXCL  = 2'd1,
        OP_EVICT = 2'd2
    } dirc_op_e;

    typedef enum logic {
        CMD_INV = 1'b0,
        CMD_WB  = 1'b1
    } dirc_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INV_WAIT,
        ST_WB_WAIT,
        ST_GRANT
    } dirc_state_e;

    // codes with the upper bit set are evictions
    function automatic dirc_op_e decode_op(input logic [1:0] code);
        if (code[1])      return OP_EVICT;
        else if (code[0]) return OP_EXCL;
        else              return OP_READ;
    endfunction

endpackage

// File: rtl/dirc_arbiter.sv
module dirc_arbiter #(
    parameter int N_AGENTS = 4,
    localparam int AGENT_W = $clog2(N_AGENTS)
) (
    input  logic               en,
    input  logic [N_AGENTS-1:0] valid,
    output logic [N_AGENTS-1:0] ready,
    output logic               any,
    output logic [AGENT_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (valid[i]) begin
                any = 1'b1;
                idx = AGENT_W'(i);
            end
        end
        ready = '0;
        if (en && any) ready[idx] = 1'b1;
    end
endmodule

// File: rtl/dirc_ack_tracker.sv
module dirc_ack_tracker #(
    parameter int N_AGENTS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [N_AGENTS-1:0] load_vec,
    input  logic [N_AGENTS-1:0] ack,
    output logic               done
);
    logic [N_AGENTS-1:0] pending_q;

    assign done = (pending_q & ~ack) == '0;

    always_ff @(posedge clk) begin
        if (rst)       pending_q <= '0;
        else if (load) pending_q <= load_vec;
        else           pending_q <= pending_q & ~ack;
    end
endmodule

// File: rtl/dirc_dir_store.sv
module dirc_dir_store
    import dirc_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int N_LINES  = 16,
    localparam int AGENT_W = $clog2(N_AGENTS),
    localparam int LINE_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINE_W-1:0]  rd_line,
    output logic [N_AGENTS-1:0] rd_pres,
    output logic               rd_ownv,
    output logic [AGENT_W-1:0] rd_own,
    input  logic               upd_en,
    input  logic [LINE_W-1:0]  upd_line,
    input  logic [AGENT_W-1:0] upd_agent,
    input  dirc_op_e           upd_op
);
    logic [N_LINES-1:0][N_AGENTS-1:0] pres_q;
    logic [N_LINES-1:0]               ownv_q;
    logic [N_LINES-1:0][AGENT_W-1:0]  own_q;

    assign rd_pres = pres_q[rd_line];
    assign rd_ownv = ownv_q[rd_line];
    assign rd_own  = own_q[rd_line];

    always_ff @(posedge clk) begin
        if (rst) begin
            pres_q <= '0;
            ownv_q <= '0;
            own_q  <= '0;
        end else if (upd_en) begin
            case (upd_op)
                OP_READ: begin
                    pres_q[upd_line][upd_agent] <= 1'b1;
                    if (ownv_q[upd_line] && own_q[upd_line] != upd_agent)
                        ownv_q[upd_line] <= 1'b0;
                end
                OP_EXCL: begin
                    pres_q[upd_line] <= N_AGENTS'(1) << upd_agent;
                    ownv_q[upd_line] <= 1'b1;
                    own_q[upd_line]  <= upd_agent;
                end
                default: begin
                    pres_q[upd_line][upd_agent] <= 1'b0;
                    if (ownv_q[upd_line] && own_q[upd_line] == upd_agent)
                        ownv_q[upd_line] <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
    import dirc_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int N_LINES  = 16,
    localparam int AGENT_W = $clog2(N_AGENTS),
    localparam int LINE_W  = $clog2(N_LINES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_AGENTS-1:0]        req_valid,
    input  logic [2*N_AGENTS-1:0]      req_op,
    input  logic [LINE_W*N_AGENTS-1:0] req_line,
    output logic [N_AGENTS-1:0]        req_ready,
    output logic [N_AGENTS-1:0]        cmd_valid,
    output logic                       cmd_kind,
    output logic [LINE_W-1:0]          cmd_line,
    input  logic [N_AGENTS-1:0]        ack_valid,
    input  logic                       wb_done,
    output logic                       gnt_valid,
    output logic [AGENT_W-1:0]         gnt_agent,
    output logic [1:0]                 gnt_op,
    output logic [LINE_W-1:0]          gnt_line
);
    dirc_state_e         st_q;
    logic [AGENT_W-1:0]  txn_agent_q;
    dirc_op_e            txn_op_q;
    logic [LINE_W-1:0]   txn_line_q;
    logic [N_AGENTS-1:0] cmd_valid_q;
    dirc_cmd_e           cmd_kind_q;

    logic                sel_any;
    logic [AGENT_W-1:0]  sel_idx;
    logic [LINE_W-1:0]   sel_line;
    dirc_op_e            sel_op;
    logic                accept;
    logic [N_AGENTS-1:0] rd_pres;
    logic                rd_ownv;
    logic [AGENT_W-1:0]  rd_own;
    logic [N_AGENTS-1:0] inv_targets;
    logic                foreign_owner;
    logic                acks_done;
    logic                in_grant;

    dirc_arbiter #(.N_AGENTS(N_AGENTS)) u_arb (
        .en    (st_q == ST_IDLE),
        .valid (req_valid),
        .ready (req_ready),
        .any   (sel_any),
        .idx   (sel_idx)
    );

    assign sel_line = req_line[sel_idx*LINE_W +: LINE_W];
    assign sel_op   = decode_op(req_op[sel_idx*2 +: 2]);
    assign accept   = (st_q == ST_IDLE) && sel_any;
    assign in_grant = (st_q == ST_GRANT);

    dirc_dir_store #(.N_AGENTS(N_AGENTS), .N_LINES(N_LINES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_line   (sel_line),
        .rd_pres   (rd_pres),
        .rd_ownv   (rd_ownv),
        .rd_own    (rd_own),
        .upd_en    (in_grant),
        .upd_line  (txn_line_q),
        .upd_agent (txn_agent_q),
        .upd_op    (txn_op_q)
    );

    assign inv_targets   = rd_pres & ~(N_AGENTS'(1) << sel_idx);
    assign foreign_owner = rd_ownv && (rd_own != sel_idx);

    dirc_ack_tracker #(.N_AGENTS(N_AGENTS)) u_acks (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && sel_op == OP_EXCL && inv_targets != '0),
        .load_vec (inv_targets),
        .ack      (ack_valid),
        .done     (acks_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            txn_agent_q <= '0;
            txn_op_q    <= OP_READ;
            txn_line_q  <= '0;
            cmd_valid_q <= '0;
            cmd_kind_q  <= CMD_INV;
        end else begin
            cmd_valid_q <= '0;
            case (st_q)
                ST_IDLE: if (accept) begin
                    txn_agent_q <= sel_idx;
                    txn_op_q    <= sel_op;
                    txn_line_q  <= sel_line;
                    st_q        <= ST_GRANT;
                    if (sel_op == OP_EXCL && inv_targets != '0) begin
                        cmd_valid_q <= inv_targets;
                        cmd_kind_q  <= CMD_INV;
                        st_q        <= ST_INV_WAIT;
                    end else if (sel_op == OP_READ && foreign_owner) begin
                        cmd_valid_q <= N_AGENTS'(1) << rd_own;
                        cmd_kind_q  <= CMD_WB;
                        st_q        <= ST_WB_WAIT;
                    end
                end
                ST_INV_WAIT: if (acks_done) st_q <= ST_GRANT;
                ST_WB_WAIT:  if (wb_done)   st_q <= ST_GRANT;
                default:     st_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_valid = cmd_valid_q;
    assign cmd_kind  = cmd_kind_q;
    assign cmd_line  = txn_line_q;
    assign gnt_valid = in_grant;
    assign gnt_agent = txn_agent_q;
    assign gnt_op    = txn_op_q;
    assign gnt_line  = txn_line_q;
endmodule

// File: rtl/dir_coherence_ctrl_chk.sv
module dirc_port_chk #(
    parameter int N_AGENTS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_AGENTS-1:0] req_valid,
    input logic [N_AGENTS-1:0] req_ready,
    input logic [N_AGENTS-1:0] cmd_valid,
    input logic               cmd_kind,
    input logic               gnt_valid
);
    a_r8_single_ready: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    a_r8_busy_stalls: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid || (|cmd_valid)) |-> (req_ready == '0));

    // R4 and R6: a command never targets the agent whose request was just taken
    a_r4_cmd_skips_requester: assert property (@(posedge clk) disable iff (rst)
        (|cmd_valid) |-> ((cmd_valid & $past(req_valid & req_ready)) == '0));

    a_r6_wb_single_target: assert property (@(posedge clk) disable iff (rst)
        ((|cmd_valid) && cmd_kind) |-> $onehot(cmd_valid));

    a_r10_grant_without_cmd: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (cmd_valid == '0));
endmodule

module dirc_store_chk #(
    parameter int N_AGENTS = 4,
    parameter int N_LINES  = 16,
    localparam int AGENT_W = $clog2(N_AGENTS)
) (
    input logic                             clk,
    input logic                             rst,
    input logic [N_LINES-1:0][N_AGENTS-1:0] pres_q,
    input logic [N_LINES-1:0]               ownv_q,
    input logic [N_LINES-1:0][AGENT_W-1:0]  own_q
);
    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        a_r7_owner_sole_holder: assert property (@(posedge clk) disable iff (rst)
            ownv_q[l] |-> (pres_q[l] == (N_AGENTS'(1) << own_q[l])));
    end
endmodule

bind dir_coherence_ctrl dirc_port_chk #(.N_AGENTS(N_AGENTS)) u_port_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .gnt_valid (gnt_valid)
);

bind dirc_dir_store dirc_store_chk #(.N_AGENTS(N_AGENTS), .N_LINES(N_LINES)) u_store_chk (
    .clk    (clk),
    .rst    (rst),
    .pres_q (pres_q),
    .ownv_q (ownv_q),
    .own_q  (own_q)
);

// File: tb/tb_dir_coherence_ctrl.sv
module tb_dir_coherence_ctrl;
    localparam int N  = 4;
    localparam int NL = 16;
    localparam int LW = 4;
    localparam int AW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [LW*N-1:0] req_line = '0;
    logic [N-1:0]    req_ready;
    logic [N-1:0]    cmd_valid;
    logic            cmd_kind;
    logic [LW-1:0]   cmd_line;
    logic [N-1:0]    ack_valid = '0;
    logic            wb_done = 1'b0;
    logic            gnt_valid;
    logic [AW-1:0]   gnt_agent;
    logic [1:0]      gnt_op;
    logic [LW-1:0]   gnt_line;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    dir_coherence_ctrl #(.N_AGENTS(N), .N_LINES(NL)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_line(req_line), .req_ready(req_ready),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_line(cmd_line),
        .ack_valid(ack_valid), .wb_done(wb_done),
        .gnt_valid(gnt_valid), .gnt_agent(gnt_agent), .gnt_op(gnt_op), .gnt_line(gnt_line)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one request, confirm acceptance, return one cycle after it
    task automatic send(input int a, input int op, input int ln);
        @(negedge clk);
        req_valid[a] = 1'b1;
        req_op[a*2 +: 2] = op[1:0];
        req_line[a*LW +: LW] = ln[LW-1:0];
        #1;
        chk_eq("R8 request accepted", int'(req_ready[a]), 1);
        @(negedge clk);
        req_valid[a] = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input int a, input int op, input int ln);
        chk_eq({tag, " grant raised"}, int'(gnt_valid), 1);
        chk_eq({tag, " R10 agent"}, int'(gnt_agent), a);
        chk_eq({tag, " R10 op"}, int'(gnt_op), op);
        chk_eq({tag, " R10 line"}, int'(gnt_line), ln);
        chk_eq({tag, " no command"}, int'(cmd_valid), 0);
        @(negedge clk);
    endtask

    task automatic expect_cmd(input string tag, input int vec, input int kind, input int ln);
        chk_eq({tag, " cmd targets"}, int'(cmd_valid), vec);
        chk_eq({tag, " cmd kind"}, int'(cmd_kind), kind);
        chk_eq({tag, " cmd line"}, int'(cmd_line), ln);
        chk_eq({tag, " no grant yet"}, int'(gnt_valid), 0);
    endtask

    task automatic pulse_ack(input logic [N-1:0] v);
        ack_valid = v;
        @(negedge clk);
        ack_valid = '0;
    endtask

    task automatic pulse_wb();
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 no grant after reset", int'(gnt_valid), 0);
        chk_eq("R1 no command after reset", int'(cmd_valid), 0);
        chk_eq("R1 no ready without request", int'(req_ready), 0);
        send(3, 0, 9);
        expect_grant("R1 first read of empty line", 3, 0, 9);
    endtask

    task automatic t_shared_reads();
        send(1, 0, 3);
        expect_grant("R2 read agent1", 1, 0, 3);
        send(2, 0, 3);
        expect_grant("R2 read agent2", 2, 0, 3);
    endtask

    task automatic t_excl_with_sharers();
        send(0, 1, 3);
        expect_cmd("R4 invalidate sharers", 4'b0110, 0, 3);
        req_valid[3] = 1'b1;
        #1;
        chk_eq("R8 stalled while busy", int'(req_ready), 0);
        req_valid[3] = 1'b0;
        pulse_ack(4'b0001);
        chk_eq("R5 stray ack ignored", int'(gnt_valid), 0);
        pulse_ack(4'b0010);
        chk_eq("R5 one ack outstanding", int'(gnt_valid), 0);
        pulse_ack(4'b0010);
        chk_eq("R5 repeated ack ignored", int'(gnt_valid), 0);
        pulse_ack(4'b0100);
        expect_grant("R5 grant after last ack", 0, 1, 3);
    endtask

    task automatic t_excl_after_owner();
        send(3, 1, 3);
        expect_cmd("R7 only previous owner invalidated", 4'b0001, 0, 3);
        pulse_ack(4'b0001);
        expect_grant("R7 exclusive grant", 3, 1, 3);
    endtask

    task automatic t_read_owned();
        send(1, 0, 3);
        expect_cmd("R6 writeback to owner", 4'b1000, 1, 3);
        @(negedge clk);
        chk_eq("R6 waits for wb_done", int'(gnt_valid), 0);
        pulse_wb();
        expect_grant("R6 grant after writeback", 1, 0, 3);
        send(2, 1, 3);
        expect_cmd("R7 owner and reader both sharers", 4'b1010, 0, 3);
        pulse_ack(4'b1010);
        expect_grant("R7 grant after joint ack", 2, 1, 3);
    endtask

    task automatic t_excl_empty();
        send(0, 1, 5);
        expect_grant("R3 exclusive on empty line", 0, 1, 5);
        pulse_wb();
        send(1, 0, 5);
        expect_cmd("R6 writeback line5", 4'b0001, 1, 5);
        @(negedge clk);
        chk_eq("R6 earlier wb_done ignored", int'(gnt_valid), 0);
        pulse_wb();
        expect_grant("R6 grant line5", 1, 0, 5);
        send(2, 0, 5);
        expect_grant("R2 read of demoted line", 2, 0, 5);
    endtask

    task automatic t_evict();
        send(2, 2, 3);
        expect_grant("R9 evict code2", 2, 2, 3);
        send(1, 1, 3);
        expect_grant("R9 R3 exclusive after evict", 1, 1, 3);
        send(1, 3, 3);
        expect_grant("R9 evict code3", 1, 2, 3);
        send(0, 0, 3);
        expect_grant("R9 ownership cleared", 0, 0, 3);
    endtask

    task automatic t_arbitration();
        @(negedge clk);
        req_valid = 4'b0110;
        req_op = '0;
        req_line[1*LW +: LW] = 4'd7;
        req_line[2*LW +: LW] = 4'd7;
        #1;
        chk_eq("R8 lowest index wins", int'(req_ready), 4'b0010);
        @(negedge clk);
        req_valid[1] = 1'b0;
        chk_eq("R8 no ready during grant", int'(req_ready), 0);
        expect_grant("R8 first winner", 1, 0, 7);
        #1;
        chk_eq("R8 waiting agent served next", int'(req_ready), 4'b0100);
        @(negedge clk);
        req_valid[2] = 1'b0;
        expect_grant("R8 second winner", 2, 0, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_shared_reads();
        t_excl_with_sharers();
        t_excl_after_owner();
        t_read_owned();
        t_excl_empty();
        t_evict();
        t_arbitration();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule